// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge

This block keeps the pending-request and in-service state for a bank of eight interrupt lines. Each line is sampled through a two-flop synchronizer and then captured either as a level or as a rising edge, chosen per line by a trigger-select register. Software loads that register through a write port. A per-instance constant mask decides which of its bits can be written at all.

An upstream priority resolver decides which line wins. A command decoder issues acknowledges, end-of-interrupt clears and poll requests. This block applies their effects to its state. An acknowledge names a line. The block then marks that line in service, or, in automatic end-of-interrupt mode, leaves the in-service state alone and may rotate the priority offset. Only for an edge-sensitive line does it also clear the pending request.

A poll read is an acknowledge driven by the block itself. While the poll flag is armed, a read acknowledges the resolver's winning line. It returns a status byte holding that line number with the top bit set, or zero when nothing is pending. The read also disarms the flag.

Top module: `irq_capture_ack`

## Requirements
- R1: A change on `irq_in[i]` reaches the request state through two synchronizer stages plus the capture register. A level change driven before clock edge k is visible on `irr` after edge k+2 (for a level line) and not after edge k+1.
- R2: A line whose `trig_sel` bit is 1 is level-sensitive. Its `irr` bit follows the synchronized input, and an acknowledge of that line never clears it.
- R3: A line whose `trig_sel` bit is 0 is edge-sensitive. Its `irr` bit is set when the synchronized input is high and the previous synchronized level was low. A falling input does not clear `irr`, and a new high level while `irr` is already set leaves it set.
- R4: An acknowledge with `auto_eoi` = 0 sets `isr[line]`. For an edge-sensitive line it also clears `irr[line]`.
- R5: An acknowledge with `auto_eoi` = 1 leaves `isr` unchanged. If `rot_aeoi` = 1, `prio_ofs` becomes (line + 1) mod 8. If `rot_aeoi` = 0, `prio_ofs` keeps its value.
- R6: When an acknowledge of an edge line and a newly detected rising edge on that same line fall in one cycle, the clear is applied first and the set second, so `irr[line]` ends at 1.
- R7: Each bit set in `isr_clr` clears the matching `isr` bit on the next edge. A same-cycle acknowledge of that line takes precedence, and the bit ends set.
- R8: `poll_arm` sets `poll_flag`. When `poll_rd` = 1 while `poll_flag` = 1 and `win_valid` = 1, `win_line` is acknowledged as in R4/R5 and `poll_data` becomes 0x80 | line. When `poll_rd` = 1 while `poll_flag` = 1 and `win_valid` = 0, `poll_data` becomes 0x00 and nothing is acknowledged. In both cases `poll_flag` clears unless `poll_arm` is also high. A `poll_rd` with `poll_flag` = 0 has no effect.
- R9: A write with `trig_wr` = 1 loads `trig_sel` with `trig_wdata & TRIG_WMASK`. Bits outside the mask stay 0.
- R10: A synchronous active-low reset clears `irr`, `isr`, `trig_sel`, `prio_ofs`, `poll_flag`, `poll_data` and the synchronizer and edge history.
- R11: In a cycle where a poll read is taken (`poll_rd` with `poll_flag` set), `ack_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Asynchronous interrupt request lines |
| trig_wr | input | 1 | Write strobe for the trigger-select register |
| trig_wdata | input | 8 | Trigger-select write data (1 = level, 0 = edge) |
| ack_valid | input | 1 | Acknowledge strobe from the command path |
| ack_line | input | 3 | Line being acknowledged |
| auto_eoi | input | 1 | Automatic end-of-interrupt mode |
| rot_aeoi | input | 1 | Rotate priority on automatic end-of-interrupt |
| isr_clr | input | 8 | In-service bits to clear (end-of-interrupt) |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | 3 | Winning line from the resolver |
| poll_arm | input | 1 | Arms the poll flag |
| poll_rd | input | 1 | Poll read strobe |
| trig_sel | output | 8 | Trigger-select register |
| irr | output | 8 | Pending request bits |
| isr | output | 8 | In-service bits |
| prio_ofs | output | 3 | Priority rotation offset |
| poll_flag | output | 1 | Poll armed |
| poll_data | output | 8 | Status byte of the last taken poll read |

## Verification
The edge lines are driven with single pulses, held highs, repeated highs while a request is still pending, and a rising edge timed to land on the same cycle as an acknowledge of that line. These patterns separate true edge capture from level following, and they show whether clear-then-set ordering holds. The level lines are acknowledged while their input stays high and then dropped, which shows whether an acknowledge wrongly clears them. A long random phase then mixes trigger rewrites, acknowledges under every auto-EOI/rotate combination, end-of-interrupt clears, and armed and unarmed poll reads. A behavioural model checks every output on every clock through all of it.

// File: rtl/irqcap_pkg.sv
// Shared types and helpers for the interrupt capture/acknowledge block.
// Assumes an 8-bit status byte for poll reads.
package irqcap_pkg;
    localparam int STAT_W = 8;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    // Builds the poll status byte: top bit flags a hit, low bits carry the line.
    function automatic logic [STAT_W-1:0] poll_status(input logic hit,
                                                      input logic [STAT_W-2:0] line_ext);
        return hit ? {1'b1, line_ext} : '0;
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for asynchronous interrupt inputs.
// Assumes each bit is independent; no multi-bit coherency is provided.
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Later stages shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
// Per-line request capture: level lines follow the synchronized input,
// edge lines latch a rising edge against a previous-level shadow.
// Assumes lvl is already synchronous; a clear for a line is applied
// before a same-cycle edge set on it.
module irq_capture
    import irqcap_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lvl,
    input  logic [N_LINES-1:0] trig_sel,
    input  logic               clr_fire,
    input  logic [IDX_W-1:0]   clr_line,
    output logic [N_LINES-1:0] irr
);
    logic [N_LINES-1:0] irr_q;
    logic [N_LINES-1:0] shadow_q;

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            logic hit_clr;
            logic rise;
            assign hit_clr = clr_fire && (clr_line == IDX_W'(i));
            assign rise    = lvl[i] && !shadow_q[i];

            // Updates the request and shadow bits of one line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    irr_q[i]    <= 1'b0;
                    shadow_q[i] <= 1'b0;
                end else begin
                    shadow_q[i] <= lvl[i];
                    if (trig_mode_e'(trig_sel[i]) == TRIG_LEVEL)
                        irr_q[i] <= lvl[i];
                    else
                        irr_q[i] <= (irr_q[i] && !hit_clr) || rise;
                end
            end
        end
    endgenerate

    assign irr = irr_q;
endmodule

// File: rtl/irq_ack_ctrl.sv
// Acknowledge handling: selects the acknowledge source (poll or command),
// updates in-service bits, the priority offset and the poll status byte.
// Assumes N_LINES is a power of two so that the offset wraps naturally.
module irq_ack_ctrl
    import irqcap_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_line,
    input  logic               auto_eoi,
    input  logic               rot_aeoi,
    input  logic [N_LINES-1:0] isr_clr,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_line,
    input  logic               poll_arm,
    input  logic               poll_rd,
    output logic               fire,
    output logic [IDX_W-1:0]   fire_line,
    output logic [N_LINES-1:0] isr,
    output logic [IDX_W-1:0]   prio_ofs,
    output logic               poll_flag,
    output logic [STAT_W-1:0]  poll_data
);
    logic               poll_take;
    logic               poll_hit;
    logic [N_LINES-1:0] isr_q, isr_n;
    logic [IDX_W-1:0]   prio_q;
    logic               pflag_q;
    logic [STAT_W-1:0]  pdata_q;

    // Chooses the acknowledge source; a taken poll read masks the command strobe.
    always_comb begin
        poll_take = poll_rd && pflag_q;
        poll_hit  = poll_take && win_valid;
        fire      = poll_hit || (ack_valid && !poll_take);
        fire_line = poll_hit ? win_line : ack_line;
    end

    // Next in-service vector: clears first, then the acknowledge set.
    always_comb begin
        isr_n = isr_q & ~isr_clr;
        if (fire && !auto_eoi)
            isr_n[fire_line] = 1'b1;
    end

    // Registers in-service bits and the priority offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q  <= '0;
            prio_q <= '0;
        end else begin
            isr_q <= isr_n;
            if (fire && auto_eoi && rot_aeoi)
                prio_q <= fire_line + IDX_W'(1);
        end
    end

    // Poll flag arming/disarming and the status byte of a taken poll read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pflag_q <= 1'b0;
            pdata_q <= '0;
        end else begin
            pflag_q <= poll_arm || (pflag_q && !poll_rd);
            if (poll_take)
                pdata_q <= poll_status(poll_hit, (STAT_W-1)'(win_line));
        end
    end

    assign isr       = isr_q;
    assign prio_ofs  = prio_q;
    assign poll_flag = pflag_q;
    assign poll_data = pdata_q;
endmodule

// File: rtl/irq_capture_ack.sv
// Top of the interrupt request capture and acknowledge block.
// Holds the trigger-select register and wires synchronizer, capture and
// acknowledge logic. Priority resolution and command decode are external.
module irq_capture_ack
    import irqcap_pkg::*;
#(
    parameter int                 N_LINES     = 8,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [N_LINES-1:0] TRIG_WMASK  = '1,
    localparam int                IDX_W       = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               trig_wr,
    input  logic [N_LINES-1:0] trig_wdata,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_line,
    input  logic               auto_eoi,
    input  logic               rot_aeoi,
    input  logic [N_LINES-1:0] isr_clr,
    input  logic               win_valid,
    input  logic [IDX_W-1:0]   win_line,
    input  logic               poll_arm,
    input  logic               poll_rd,
    output logic [N_LINES-1:0] trig_sel,
    output logic [N_LINES-1:0] irr,
    output logic [N_LINES-1:0] isr,
    output logic [IDX_W-1:0]   prio_ofs,
    output logic               poll_flag,
    output logic [STAT_W-1:0]  poll_data
);
    logic [N_LINES-1:0] lvl_sync;
    logic [N_LINES-1:0] trig_q;
    logic               ack_fire;
    logic [IDX_W-1:0]   ack_sel;

    // Trigger-select register, written through the writable-bit mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       trig_q <= '0;
        else if (trig_wr) trig_q <= trig_wdata & TRIG_WMASK;
    end
    assign trig_sel = trig_q;

    irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_in),
        .q_sync  (lvl_sync)
    );

    irq_capture #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sync),
        .trig_sel (trig_q),
        .clr_fire (ack_fire),
        .clr_line (ack_sel),
        .irr      (irr)
    );

    irq_ack_ctrl #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_valid (ack_valid),
        .ack_line  (ack_line),
        .auto_eoi  (auto_eoi),
        .rot_aeoi  (rot_aeoi),
        .isr_clr   (isr_clr),
        .win_valid (win_valid),
        .win_line  (win_line),
        .poll_arm  (poll_arm),
        .poll_rd   (poll_rd),
        .fire      (ack_fire),
        .fire_line (ack_sel),
        .isr       (isr),
        .prio_ofs  (prio_ofs),
        .poll_flag (poll_flag),
        .poll_data (poll_data)
    );
endmodule

// File: rtl/irq_capture_ack_checker.sv
// Port-level properties of the capture/acknowledge block, bound to the top.
module irq_capture_ack_checker #(
    parameter int                 N_LINES    = 8,
    parameter logic [N_LINES-1:0] TRIG_WMASK = '1,
    localparam int                IDX_W      = $clog2(N_LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               trig_wr,
    input logic [N_LINES-1:0] trig_wdata,
    input logic               ack_valid,
    input logic [IDX_W-1:0]   ack_line,
    input logic               auto_eoi,
    input logic               rot_aeoi,
    input logic [N_LINES-1:0] isr_clr,
    input logic               win_valid,
    input logic [IDX_W-1:0]   win_line,
    input logic               poll_arm,
    input logic               poll_rd,
    input logic [N_LINES-1:0] trig_sel,
    input logic [N_LINES-1:0] irr,
    input logic [N_LINES-1:0] isr,
    input logic [IDX_W-1:0]   prio_ofs,
    input logic               poll_flag,
    input logic [7:0]         poll_data
);
    logic             take;
    logic             hit;
    logic             cfire;
    logic [IDX_W-1:0] cline;
    assign take  = poll_rd && poll_flag;
    assign hit   = take && win_valid;
    assign cfire = hit || (ack_valid && !take);
    assign cline = hit ? win_line : ack_line;

    assert_trig_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> trig_sel == ($past(trig_wdata) & TRIG_WMASK));

    assert_isr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfire && !auto_eoi) |=> isr[$past(cline)]);

    assert_aeoi_isr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfire && auto_eoi && isr_clr == '0) |=> $stable(isr));

    assert_aeoi_rotate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfire && auto_eoi && rot_aeoi) |=> prio_ofs == IDX_W'($past(cline) + 1'b1));

    assert_poll_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !poll_arm) |=> !poll_flag);

    assert_poll_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> poll_data == {1'b1, 4'b0000, $past(win_line)});

    assert_poll_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !win_valid) |=> poll_data == 8'h00);

    assert_poll_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !win_valid && isr_clr == '0) |=> $stable(isr));

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_edge
            assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (!trig_sel[i] && irr[i] && !trig_wr && !(cfire && cline == IDX_W'(i)))
                |=> irr[i]);
        end
    endgenerate
endmodule

bind irq_capture_ack irq_capture_ack_checker #(
    .N_LINES    (N_LINES),
    .TRIG_WMASK (TRIG_WMASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig_wr    (trig_wr),
    .trig_wdata (trig_wdata),
    .ack_valid  (ack_valid),
    .ack_line   (ack_line),
    .auto_eoi   (auto_eoi),
    .rot_aeoi   (rot_aeoi),
    .isr_clr    (isr_clr),
    .win_valid  (win_valid),
    .win_line   (win_line),
    .poll_arm   (poll_arm),
    .poll_rd    (poll_rd),
    .trig_sel   (trig_sel),
    .irr        (irr),
    .isr        (isr),
    .prio_ofs   (prio_ofs),
    .poll_flag  (poll_flag),
    .poll_data  (poll_data)
);

// File: tb/tb_irq_capture_ack.sv
module tb_irq_capture_ack;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] WMASK      = 8'h7E;
    localparam int         WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0, trig_wdata = '0, isr_clr = '0;
    logic       trig_wr = 0, ack_valid = 0, auto_eoi = 0, rot_aeoi = 0;
    logic       win_valid = 0, poll_arm = 0, poll_rd = 0;
    logic [2:0] ack_line = '0, win_line = '0;
    logic [7:0] trig_sel, irr, isr, poll_data;
    logic [2:0] prio_ofs;
    logic       poll_flag;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_capture_ack #(.TRIG_WMASK(WMASK)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .trig_wr(trig_wr),
        .trig_wdata(trig_wdata), .ack_valid(ack_valid), .ack_line(ack_line),
        .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .isr_clr(isr_clr),
        .win_valid(win_valid), .win_line(win_line), .poll_arm(poll_arm),
        .poll_rd(poll_rd), .trig_sel(trig_sel), .irr(irr), .isr(isr),
        .prio_ofs(prio_ofs), .poll_flag(poll_flag), .poll_data(poll_data)
    );

    // Behavioural reference state, one entry per line.
    int m_s1[8], m_s2[8], m_shd[8], m_irr[8], m_isr[8], m_trig[8];
    int m_prio = 0, m_pflag = 0, m_pdata = 0;

    function automatic int pack(input int a[8]);
        int v = 0;
        for (int i = 0; i < 8; i++) v += a[i] << i;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_shd[i] = 0;
                m_irr[i] = 0; m_isr[i] = 0; m_trig[i] = 0;
            end
            m_prio = 0; m_pflag = 0; m_pdata = 0;
        end else begin
            int take, hit, fire, ln;
            take = (poll_rd && m_pflag != 0) ? 1 : 0;
            hit  = (take != 0 && win_valid) ? 1 : 0;
            fire = (hit != 0 || (ack_valid && take == 0)) ? 1 : 0;
            ln   = (hit != 0) ? int'(win_line) : int'(ack_line);
            for (int i = 0; i < 8; i++) begin
                if (m_trig[i] != 0) m_irr[i] = m_s2[i];
                else begin
                    if (fire != 0 && ln == i) m_irr[i] = 0;
                    if (m_s2[i] != 0 && m_shd[i] == 0) m_irr[i] = 1;
                end
                m_shd[i] = m_s2[i];
                if (isr_clr[i]) m_isr[i] = 0;
            end
            if (fire != 0 && !auto_eoi) m_isr[ln] = 1;
            if (fire != 0 && auto_eoi && rot_aeoi) m_prio = (ln + 1) % 8;
            if (take != 0) m_pdata = (hit != 0) ? 128 + int'(win_line) : 0;
            m_pflag = (poll_arm || (m_pflag != 0 && !poll_rd)) ? 1 : 0;
            for (int i = 0; i < 8; i++) begin
                if (trig_wr) m_trig[i] = (trig_wdata[i] && WMASK[i]) ? 1 : 0;
                m_s2[i] = m_s1[i];
                m_s1[i] = irq_in[i] ? 1 : 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the reference model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(int'(irr) == pack(m_irr), "irr R1 R2 R3 R6", int'(irr), pack(m_irr));
            chk(int'(isr) == pack(m_isr), "isr R4 R7 R11", int'(isr), pack(m_isr));
            chk(int'(prio_ofs) == m_prio, "prio_ofs R5", int'(prio_ofs), m_prio);
            chk(int'(poll_flag) == m_pflag, "poll_flag R8", int'(poll_flag), m_pflag);
            chk(int'(poll_data) == m_pdata, "poll_data R8", int'(poll_data), m_pdata);
            chk(int'(trig_sel) == pack(m_trig), "trig_sel R9", int'(trig_sel), pack(m_trig));
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        chk(irr == 0 && isr == 0 && trig_sel == 0 && prio_ofs == 0 && !poll_flag && poll_data == 0,
            "R10 reset state", int'({irr, isr}), 0);

        // R9: masked write; lines 1..3 become level, line 0 stays edge.
        trig_wr = 1; trig_wdata = 8'hFF; step(1); trig_wr = 0;
        chk(trig_sel == 8'h7E, "R9 masked write", int'(trig_sel), 8'h7E);
        trig_wr = 1; trig_wdata = 8'h0F; step(1); trig_wr = 0;
        chk(trig_sel == 8'h0E, "R9 masked write", int'(trig_sel), 8'h0E);

        // R1: latency of a level line.
        irq_in[1] = 1; step(2);
        chk(irr[1] == 1'b0, "R1 not before third edge", int'(irr[1]), 0);
        step(1);
        chk(irr[1] == 1'b1, "R1 visible after third edge", int'(irr[1]), 1);

        // R2/R4: acknowledging a level line keeps its request.
        ack_valid = 1; ack_line = 3'd1; step(1); ack_valid = 0;
        chk(irr[1] == 1'b1, "R2 level request survives ack", int'(irr[1]), 1);
        chk(isr[1] == 1'b1, "R4 isr set on ack", int'(isr[1]), 1);
        irq_in[1] = 0; step(3);
        chk(irr[1] == 1'b0, "R2 level request follows input", int'(irr[1]), 0);

        // R3: edge line 5 latches and holds.
        irq_in[5] = 1; step(3);
        chk(irr[5] == 1'b1, "R3 edge captured", int'(irr[5]), 1);
        irq_in[5] = 0; step(4);
        chk(irr[5] == 1'b1, "R3 falling input keeps request", int'(irr[5]), 1);
        ack_valid = 1; ack_line = 3'd5; step(1); ack_valid = 0;
        chk(irr[5] == 1'b0, "R4 edge request cleared by ack", int'(irr[5]), 0);
        chk(isr[5] == 1'b1, "R4 isr set on ack", int'(isr[5]), 1);

        // R6: new edge lands in the acknowledge cycle of the same line.
        irq_in[6] = 1; step(4); irq_in[6] = 0; step(3);
        irq_in[6] = 1; step(2);
        ack_valid = 1; ack_line = 3'd6; step(1); ack_valid = 0;
        chk(irr[6] == 1'b1, "R6 set wins over same-cycle clear", int'(irr[6]), 1);

        // R7: end-of-interrupt clear, and ack precedence over it.
        isr_clr = 8'h22; step(1); isr_clr = 0;
        chk(isr[1] == 1'b0 && isr[5] == 1'b0, "R7 isr cleared", int'(isr), 0);
        isr_clr = 8'h40; ack_valid = 1; ack_line = 3'd6; step(1);
        isr_clr = 0; ack_valid = 0;
        chk(isr[6] == 1'b1, "R7 ack set beats clear", int'(isr[6]), 1);

        // R5: auto-EOI with and without rotation.
        auto_eoi = 1; rot_aeoi = 1; ack_valid = 1; ack_line = 3'd3; step(1);
        chk(prio_ofs == 3'd4, "R5 rotate to line+1", int'(prio_ofs), 4);
        chk(isr[3] == 1'b0, "R5 isr untouched", int'(isr[3]), 0);
        ack_line = 3'd7; step(1);
        chk(prio_ofs == 3'd0, "R5 rotate wraps", int'(prio_ofs), 0);
        rot_aeoi = 0; ack_line = 3'd2; step(1);
        chk(prio_ofs == 3'd0, "R5 no rotate when disabled", int'(prio_ofs), 0);
        ack_valid = 0; auto_eoi = 0;

        // R8: poll with a winner, without a winner, and unarmed.
        irq_in[4] = 1; step(3);
        poll_arm = 1; step(1); poll_arm = 0;
        chk(poll_flag == 1'b1, "R8 poll armed", int'(poll_flag), 1);
        poll_rd = 1; win_valid = 1; win_line = 3'd4; step(1); poll_rd = 0; win_valid = 0;
        chk(poll_data == 8'h84, "R8 poll status", int'(poll_data), 8'h84);
        chk(!poll_flag, "R8 poll disarms", int'(poll_flag), 0);
        chk(irr[4] == 1'b0 && isr[4] == 1'b1, "R8 poll acknowledges", int'({irr[4], isr[4]}), 1);
        poll_rd = 1; win_valid = 1; win_line = 3'd2; step(1); poll_rd = 0; win_valid = 0;
        chk(poll_data == 8'h84 && isr[2] == 1'b0, "R8 unarmed poll ignored", int'(poll_data), 8'h84);
        poll_arm = 1; step(1); poll_arm = 0;
        poll_rd = 1; step(1); poll_rd = 0;
        chk(poll_data == 8'h00, "R8 empty poll", int'(poll_data), 0);

        // R11: command ack ignored during a taken poll.
        poll_arm = 1; step(1); poll_arm = 0;
        poll_rd = 1; win_valid = 1; win_line = 3'd0; ack_valid = 1; ack_line = 3'd7;
        step(1);
        poll_rd = 0; win_valid = 0; ack_valid = 0;
        chk(isr[0] == 1'b1 && isr[7] == 1'b0, "R11 poll wins over ack", int'(isr), 1);

        // Random mix, compared every clock by the model.
        for (int c = 0; c < 3000; c++) begin
            irq_in    = ($urandom % 4 == 0) ? 8'($urandom) : irq_in;
            trig_wr   = ($urandom % 40 == 0);
            trig_wdata = 8'($urandom);
            ack_valid = ($urandom % 5 == 0);
            ack_line  = 3'($urandom);
            auto_eoi  = ($urandom % 3 == 0);
            rot_aeoi  = ($urandom % 2 == 0);
            isr_clr   = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            win_valid = ($urandom % 2 == 0);
            win_line  = 3'($urandom);
            poll_arm  = ($urandom % 10 == 0);
            poll_rd   = ($urandom % 6 == 0);
            if (c == 1500) rst_n = 0;
            if (c == 1502) rst_n = 1;
            step(1);
            if (c == 1502)
                chk(irr == 0 && isr == 0 && trig_sel == 0 && poll_data == 0,
                    "R10 mid-run reset", int'({irr, isr}), 0);
        end
        summary();
    end
endmodule